// File: doc/BRIEF.md
# Relational Flag Compare and Branch Unit

This block compares two 32-bit words and records the result as six independent relational flags: greater, greater-or-equal, less, less-or-equal, equal and not-equal. A later conditional branch picks one of those flags and, when it is set, redirects the program counter to a supplied target. When the flag is clear, the block passes through the already incremented program counter.

Each compare takes its operands from two register values and one immediate value under a mode code. The relation is always read as destination relative to source, using signed two's-complement order. The flag vector is visible at all times, so a thread switch can save it. A context load port restores all six flags in a single cycle.

The unit resolves branches combinationally from the flags currently held. The flags themselves update on the clock edge that samples a compare or a context load.

Top module: `relflag_branch_unit`

## Requirements
- R1: While reset is asserted, and directly after it, all six flags read zero.
- R2: A compare in a legal mode replaces every flag on the next clock edge. The flags bit layout is bit 5 dst>=src, bit 4 dst>src, bit 3 dst<=src, bit 2 dst<src, bit 1 dst!=src and bit 0 dst==src. Each relation is a signed 32-bit comparison.
- R3: Mode 0 compares cmpImm as source against cmpDstReg as destination. Mode 1 compares cmpSrcReg against cmpDstReg. Mode 2 compares cmpSrcReg as source against cmpImm as destination.
- R4: A compare with mode 3 is ignored, and the flags keep their value.
- R5: With neither a compare nor a context load presented, the flags hold their value.
- R6: A branch with brCond 1 (equal), 2 (not-equal), 3 (less), 4 (less-or-equal), 5 (greater) or 6 (greater-or-equal) is taken exactly when the selected flag is currently set.
- R7: brTaken and nextPc follow the inputs and the current flags in the same cycle. nextPc equals brTarget when the branch is taken and pcInc otherwise.
- R8: brCond 0 is always taken, and brCond 7 is never taken.
- R9: Without brValid, brTaken is low and nextPc equals pcInc.
- R10: A context load writes ctxFlagsIn into all six flags on the next edge. It takes priority over a compare in the same cycle.
- R11: A compare leaves no flag set from an earlier state unless the new relation holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmpValid | input | 1 | Compare strobe |
| cmpMode | input | 2 | Operand selection mode |
| cmpSrcReg | input | 32 | Source register value |
| cmpDstReg | input | 32 | Destination register value |
| cmpImm | input | 32 | Immediate operand |
| ctxLoad | input | 1 | Restore flags from a saved context |
| ctxFlagsIn | input | 6 | Saved flag vector to restore |
| brValid | input | 1 | Branch request |
| brCond | input | 3 | Branch condition selector |
| brTarget | input | 32 | Branch target address |
| pcInc | input | 32 | Already incremented program counter |
| flags | output | 6 | Current flags, also the context store value |
| brTaken | output | 1 | Branch taken |
| nextPc | output | 32 | Resolved next program counter |

## Verification
The checker enforces several invariants on every cycle:
- After any compare, the flags are mutually consistent: equal and not-equal are opposite, less is the opposite of greater-or-equal, and each inclusive flag is the union of its strict flag and equal.
- Flags hold across idle cycles and across illegal-mode compares.
- Restores copy the input exactly.
- Unconditional, never-taken and absent branch requests produce the right next program counter.

Some behaviour only the bench scenarios can show:
- The correct signed relation for each operand mode, including negative values and equal operands.
- The priority of a restore over a simultaneous compare.
- The per-condition choice of flag in a taken or fall-through branch.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_FLAGS = 6;
  localparam int COND_W    = 3;

  // flag bit positions (bit 5 down to bit 0 matches trace order)
  localparam int F_EQ = 0;
  localparam int F_NE = 1;
  localparam int F_LT = 2;
  localparam int F_LE = 3;
  localparam int F_GT = 4;
  localparam int F_GE = 5;

  typedef enum logic [1:0] {
    MODE_IMM_REG = 2'd0,
    MODE_REG_REG = 2'd1,
    MODE_REG_IMM = 2'd2,
    MODE_BAD     = 2'd3
  } cmp_mode_e;

  typedef enum logic [COND_W-1:0] {
    COND_ALWAYS = 3'd0,
    COND_EQ     = 3'd1,
    COND_NE     = 3'd2,
    COND_LT     = 3'd3,
    COND_LE     = 3'd4,
    COND_GT     = 3'd5,
    COND_GE     = 3'd6,
    COND_NEVER  = 3'd7
  } br_cond_e;

  typedef struct packed {
    logic                 ctxWr;
    logic                 cmpWr;
    logic                 srcFromImm;
    logic                 dstFromImm;
    logic                 brReq;
    logic                 brAlways;
    logic [NUM_FLAGS-1:0] brMask;
  } ctrl_strobe_t;
endpackage

// File: rtl/cbu_ctrl.sv
module cbu_ctrl
  import cbu_pkg::*;
(
  input  logic              cmpValid,
  input  logic [1:0]        cmpMode,
  input  logic              ctxLoad,
  input  logic              brValid,
  input  logic [COND_W-1:0] brCond,
  output ctrl_strobe_t      strobe
);
  always_comb begin
    strobe            = '0;
    strobe.ctxWr      = ctxLoad;
    strobe.cmpWr      = cmpValid && !ctxLoad && (cmp_mode_e'(cmpMode) != MODE_BAD);
    strobe.srcFromImm = (cmp_mode_e'(cmpMode) == MODE_IMM_REG);
    strobe.dstFromImm = (cmp_mode_e'(cmpMode) == MODE_REG_IMM);
    strobe.brReq      = brValid;
    case (br_cond_e'(brCond))
      COND_ALWAYS: strobe.brAlways   = 1'b1;
      COND_EQ:     strobe.brMask[F_EQ] = 1'b1;
      COND_NE:     strobe.brMask[F_NE] = 1'b1;
      COND_LT:     strobe.brMask[F_LT] = 1'b1;
      COND_LE:     strobe.brMask[F_LE] = 1'b1;
      COND_GT:     strobe.brMask[F_GT] = 1'b1;
      COND_GE:     strobe.brMask[F_GE] = 1'b1;
      default:     strobe.brMask     = '0;
    endcase
  end
endmodule

// File: rtl/cbu_datapath.sv
module cbu_datapath
  import cbu_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int NF = NUM_FLAGS
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrl_strobe_t  strobe,
  input  logic [W-1:0]  cmpSrcReg,
  input  logic [W-1:0]  cmpDstReg,
  input  logic [W-1:0]  cmpImm,
  input  logic [NF-1:0] ctxFlagsIn,
  input  logic [W-1:0]  brTarget,
  input  logic [W-1:0]  pcInc,
  output logic [NF-1:0] flags,
  output logic          brTaken,
  output logic [W-1:0]  nextPc
);
  logic [W-1:0]  srcOp, dstOp;
  logic [NF-1:0] relFlags;
  logic [NF-1:0] flagReg;

  assign srcOp = strobe.srcFromImm ? cmpImm : cmpSrcReg;
  assign dstOp = strobe.dstFromImm ? cmpImm : cmpDstReg;

  always_comb begin
    relFlags       = '0;
    relFlags[F_GT] = $signed(dstOp) >  $signed(srcOp);
    relFlags[F_GE] = $signed(dstOp) >= $signed(srcOp);
    relFlags[F_LT] = $signed(dstOp) <  $signed(srcOp);
    relFlags[F_LE] = $signed(dstOp) <= $signed(srcOp);
    relFlags[F_EQ] = dstOp == srcOp;
    relFlags[F_NE] = dstOp != srcOp;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             flagReg <= '0;
    else if (strobe.ctxWr) flagReg <= ctxFlagsIn;
    else if (strobe.cmpWr) flagReg <= relFlags;
  end

  assign flags   = flagReg;
  assign brTaken = strobe.brReq && (strobe.brAlways || |(flagReg & strobe.brMask));
  assign nextPc  = brTaken ? brTarget : pcInc;
endmodule

// File: rtl/relflag_branch_unit.sv
module relflag_branch_unit
  import cbu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmpValid,
  input  logic [1:0]           cmpMode,
  input  logic [WORD_W-1:0]    cmpSrcReg,
  input  logic [WORD_W-1:0]    cmpDstReg,
  input  logic [WORD_W-1:0]    cmpImm,
  input  logic                 ctxLoad,
  input  logic [NUM_FLAGS-1:0] ctxFlagsIn,
  input  logic                 brValid,
  input  logic [COND_W-1:0]    brCond,
  input  logic [WORD_W-1:0]    brTarget,
  input  logic [WORD_W-1:0]    pcInc,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 brTaken,
  output logic [WORD_W-1:0]    nextPc
);
  ctrl_strobe_t strobe;

  cbu_ctrl i_ctrl (
    .cmpValid (cmpValid),
    .cmpMode  (cmpMode),
    .ctxLoad  (ctxLoad),
    .brValid  (brValid),
    .brCond   (brCond),
    .strobe   (strobe)
  );

  cbu_datapath #(.W(WORD_W), .NF(NUM_FLAGS)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cmpSrcReg  (cmpSrcReg),
    .cmpDstReg  (cmpDstReg),
    .cmpImm     (cmpImm),
    .ctxFlagsIn (ctxFlagsIn),
    .brTarget   (brTarget),
    .pcInc      (pcInc),
    .flags      (flags),
    .brTaken    (brTaken),
    .nextPc     (nextPc)
  );
endmodule

// File: rtl/cbu_checker.sv
module cbu_checker
  import cbu_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 cmpValid,
  input logic [1:0]           cmpMode,
  input logic                 ctxLoad,
  input logic [NUM_FLAGS-1:0] ctxFlagsIn,
  input logic                 brValid,
  input logic [COND_W-1:0]    brCond,
  input logic [WORD_W-1:0]    brTarget,
  input logic [WORD_W-1:0]    pcInc,
  input logic [NUM_FLAGS-1:0] flags,
  input logic                 brTaken,
  input logic [WORD_W-1:0]    nextPc
);
  logic legalCmp;
  assign legalCmp = cmpValid && (cmpMode != 2'd3) && !ctxLoad;

  assert_reset_clear_R1: assert property (@(posedge clk) !rstN |=> flags == '0);

  assert_consistent_flags_R2: assert property (@(posedge clk) disable iff (!rstN)
    legalCmp |=> (flags[F_EQ] != flags[F_NE]) && (flags[F_LT] != flags[F_GE]) &&
                 (flags[F_GE] == (flags[F_GT] | flags[F_EQ])) &&
                 (flags[F_LE] == (flags[F_LT] | flags[F_EQ])));

  assert_bad_mode_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmpValid && cmpMode == 2'd3 && !ctxLoad) |=> $stable(flags));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!cmpValid && !ctxLoad) |=> $stable(flags));

  assert_ctx_restore_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctxLoad |=> flags == $past(ctxFlagsIn));

  assert_always_taken_R8: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && brCond == 3'd0) |-> (brTaken && nextPc == brTarget));

  assert_never_taken_R8: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && brCond == 3'd7) |-> (!brTaken && nextPc == pcInc));

  assert_no_request_R9: assert property (@(posedge clk) disable iff (!rstN)
    !brValid |-> (!brTaken && nextPc == pcInc));
endmodule

bind relflag_branch_unit cbu_checker i_chk (.*);

// File: tb/test_relflag_branch_unit.sv
`timescale 1ns/1ps
module test_relflag_branch_unit;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cmpValid;
  logic [1:0]  cmpMode;
  logic [31:0] cmpSrcReg, cmpDstReg, cmpImm;
  logic        ctxLoad;
  logic [5:0]  ctxFlagsIn;
  logic        brValid;
  logic [2:0]  brCond;
  logic [31:0] brTarget, pcInc;
  logic [5:0]  flags;
  logic        brTaken;
  logic [31:0] nextPc;

  int checks = 0;
  int errors = 0;
  logic [5:0] modelFlags;

  typedef struct packed {
    logic [5:0]  f;
    logic        t;
    logic [31:0] pc;
  } exp_t;
  exp_t  expQ[$];
  string tagQ[$];

  always #4 clk = ~clk;

  relflag_branch_unit i_relflag_branch_unit (.*);

  function automatic logic [5:0] relOf(input logic [31:0] s, input logic [31:0] d);
    logic [5:0] r;
    r[5] = $signed(d) >= $signed(s);
    r[4] = $signed(d) >  $signed(s);
    r[3] = $signed(d) <= $signed(s);
    r[2] = $signed(d) <  $signed(s);
    r[1] = d != s;
    r[0] = d == s;
    return r;
  endfunction

  function automatic logic condHit(input logic [2:0] c, input logic [5:0] f);
    case (c)
      3'd0: return 1'b1;
      3'd1: return f[0];
      3'd2: return f[1];
      3'd3: return f[2];
      3'd4: return f[3];
      3'd5: return f[4];
      3'd6: return f[5];
      default: return 1'b0;
    endcase
  endfunction

  task automatic step(input logic cv, input logic [1:0] md, input logic [31:0] s,
                      input logic [31:0] d, input logic [31:0] im, input logic cl,
                      input logic [5:0] cf, input logic bv, input logic [2:0] bc,
                      input logic [31:0] tg, input logic [31:0] pi, input string tag);
    exp_t e;
    logic [31:0] so, dso;
    @(negedge clk);
    cmpValid = cv; cmpMode = md; cmpSrcReg = s; cmpDstReg = d; cmpImm = im;
    ctxLoad = cl; ctxFlagsIn = cf; brValid = bv; brCond = bc; brTarget = tg; pcInc = pi;
    so  = (md == 2'd0) ? im : s;
    dso = (md == 2'd2) ? im : d;
    if (cl) modelFlags = cf;
    else if (cv && md != 2'd3) modelFlags = relOf(so, dso);
    e.f  = modelFlags;
    e.t  = bv && condHit(bc, modelFlags);
    e.pc = e.t ? tg : pi;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic cmp(input logic [1:0] md, input logic [31:0] s, input logic [31:0] d,
                     input logic [31:0] im, input string tag);
    step(1'b1, md, s, d, im, 1'b0, 6'h0, 1'b0, 3'd0, 32'h0, 32'h100, tag);
  endtask

  task automatic br(input logic [2:0] c, input logic [31:0] tg, input logic [31:0] pi,
                    input string tag);
    step(1'b0, 2'd1, 32'h0, 32'h0, 32'h0, 1'b0, 6'h0, 1'b1, c, tg, pi, tag);
  endtask

  // monitor: sample 2 ns after the edge, before the driver's next negedge update
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        exp_t e;
        string tg;
        e  = expQ.pop_front();
        tg = tagQ.pop_front();
        checks++;
        if (flags !== e.f || brTaken !== e.t || nextPc !== e.pc) begin
          errors++;
          $display("FAIL %s: flags=%b taken=%b nextPc=%h expected flags=%b taken=%b nextPc=%h",
                   tg, flags, brTaken, nextPc, e.f, e.t, e.pc);
        end
      end
    end
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; cmpValid = 0; cmpMode = 0; cmpSrcReg = 0; cmpDstReg = 0; cmpImm = 0;
    ctxLoad = 0; ctxFlagsIn = 0; brValid = 0; brCond = 0; brTarget = 0; pcInc = 0;
    modelFlags = 6'h0;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (flags !== 6'h0) begin
      errors++;
      $display("FAIL R1: flags=%b expected %b", flags, 6'h0);
    end
    @(negedge clk);
    rstN = 1'b1;

    // R2/R3: register against register
    cmp(2'd1, 32'd3, 32'd5, 32'd0, "R2 reg-reg dst>src");
    cmp(2'd1, 32'd7, 32'd7, 32'd0, "R2 reg-reg equal");
    cmp(2'd1, 32'd9, 32'hFFFF_FFFE, 32'd0, "R2 signed negative dst");
    cmp(2'd1, 32'h8000_0000, 32'h7FFF_FFFF, 32'd0, "R2 signed extremes");
    // R3: immediate source / immediate destination
    cmp(2'd0, 32'd100, 32'd4, 32'd4, "R3 imm-reg equal");
    cmp(2'd0, 32'd0, 32'd2, 32'd10, "R3 imm-reg less");
    cmp(2'd2, 32'd10, 32'd0, 32'd2, "R3 reg-imm less");
    cmp(2'd2, 32'hFFFF_FFF0, 32'd0, 32'd1, "R3 reg-imm greater");
    // R4: illegal mode ignored
    cmp(2'd3, 32'd1, 32'd1, 32'd0, "R4 mode3 ignored");
    // R5: idle cycles hold
    step(1'b0, 2'd1, 32'd9, 32'd1, 32'd0, 1'b0, 6'h0, 1'b0, 3'd0, 32'h0, 32'h40, "R5 idle hold");
    step(1'b0, 2'd0, 32'd9, 32'd1, 32'd0, 1'b0, 6'h0, 1'b0, 3'd0, 32'h0, 32'h44, "R5 idle hold");
    // R6/R7: branches on flags from dst>src
    cmp(2'd1, 32'd1, 32'd2, 32'd0, "R2 setup greater");
    for (int c = 1; c <= 6; c++)
      br(c[2:0], 32'h200 + c, 32'h50 + c, "R6 cond select greater state");
    cmp(2'd1, 32'd5, 32'd5, 32'd0, "R2 setup equal");
    for (int c = 1; c <= 6; c++)
      br(c[2:0], 32'h300 + c, 32'h60 + c, "R7 cond select equal state");
    // R8
    br(3'd0, 32'hABC, 32'h70, "R8 always taken");
    br(3'd7, 32'hABC, 32'h71, "R8 never taken");
    // R9
    step(1'b0, 2'd1, 0, 0, 0, 1'b0, 6'h0, 1'b0, 3'd1, 32'h999, 32'h72, "R9 no request");
    // R10: restore, and priority over compare
    step(1'b0, 2'd1, 0, 0, 0, 1'b1, 6'b101010, 1'b0, 3'd0, 0, 32'h80, "R10 restore");
    step(1'b1, 2'd1, 32'd1, 32'd1, 0, 1'b1, 6'b000111, 1'b0, 3'd0, 0, 32'h84, "R10 restore beats compare");
    // R11: all flags set, then a compare clears stale ones
    step(1'b0, 2'd1, 0, 0, 0, 1'b1, 6'b111111, 1'b0, 3'd0, 0, 32'h88, "R10 restore all");
    cmp(2'd1, 32'd4, 32'd3, 32'd0, "R11 stale flags cleared");
    // compare and branch in one cycle: branch sees post-edge flags at sample time
    step(1'b1, 2'd1, 32'd2, 32'd9, 0, 1'b0, 6'h0, 1'b1, 3'd5, 32'h500, 32'h90, "R6 branch after compare");

    repeat (4) @(posedge clk);
    #3;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule